// File: doc/BRIEF.md
# Split-Operand Multiplier Combiner

This block forms the unsigned product of two wide operands from four narrower multiplies. Each of those multiplies fits a fixed hard multiplier. Operand A is cut into a low part of `SA` bits and a high part. Operand B is cut into a low part of `SB` bits and a high part. The four cross products of these parts are then merged by a small adder network, and the result is cut down to the configured product width.

The split sizes come from the two port widths of the hard multiplier. If operand B is wider than the multiplier's B port, the two port assignments trade places before the split is worked out.

The combining network is chosen when the block is built:
- **Unequal split sizes.** A three-adder arrangement is used:
  - a cross-sum adder, one bit wider than its inputs;
  - a carry-free merge of the high-high and low-low products;
  - a final adder.
- **Equal split sizes.** A two-adder arrangement is used instead. It passes the low product bits straight through.

An optional output register, cleared by reset, adds one cycle of latency. There are no states: the block is a data path with at most one register stage.

Top module: `smc_mult`

## Requirements
- R1: For all unsigned operands, `prod` equals the low `P_W` bits of `op_a * op_b`.
- R2: With unequal split sizes, the carry out of the cross-product sum (`A1*B0` shifted by `SA` plus `A0*B1` shifted by `SB`) is kept, so operands whose cross products are both at their maximum still give the exact product.
- R3: With equal split sizes `S`, `prod[S-1:0]` equals the low `S` bits of `op_a[S-1:0] * op_b[S-1:0]`.
- R4: When `B_W > HARD_B`, operand A is split at `HARD_B` bits and operand B at `HARD_A` bits, and the product is still exact.
- R5: When `P_W` is below `A_W + B_W`, only the least significant `P_W` bits of the full product appear on `prod`.
- R6: With `REG_OUT = 1`, `prod` shows the product of the operands sampled at the previous rising clock edge. With `REG_OUT = 0`, `prod` follows the operands within the same cycle.
- R7: With `REG_OUT = 1`, `prod` is zero while `rst_n` is low, whatever the operands are.
- R8: A zero value on either operand gives `prod = 0`.
- R9: All-ones operands give the low `P_W` bits of `(2^A_W - 1) * (2^B_W - 1)`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset for the output register |
| op_a | input | A_W | Unsigned multiplicand |
| op_b | input | B_W | Unsigned multiplier |
| prod | output | P_W | Product, truncated to P_W bits |

## Verification
The hardest case to reach from the ports is a carry out of the cross-product adder in the unequal arrangement. That carry only appears when both cross products are near their maximum at the same time. Uniform random operands rarely produce this. The stimulus therefore drives the high parts and the low parts of both operands to all ones directly, together with near-maximum mixes of those fields. Every result is compared with a direct wide multiplication, for both an unequal-split registered build and an equal-split, truncated combinational build.

// File: rtl/smc_pkg.sv
package smc_pkg;

    function automatic int smc_max(input int x, input int y);
        return (x > y) ? x : y;
    endfunction

    function automatic int smc_min(input int x, input int y);
        return (x < y) ? x : y;
    endfunction

    // split size applied to operand A after the port-swap decision
    function automatic int smc_split_a(input int b_w, input int hard_a, input int hard_b);
        return (b_w > hard_b) ? hard_b : hard_a;
    endfunction

    // split size applied to operand B after the port-swap decision
    function automatic int smc_split_b(input int b_w, input int hard_a, input int hard_b);
        return (b_w > hard_b) ? hard_a : hard_b;
    endfunction

endpackage

// File: rtl/smc_part_mul.sv
module smc_part_mul #(
    parameter int XW = 8,
    parameter int YW = 8
) (
    input  logic [XW-1:0]    x,
    input  logic [YW-1:0]    y,
    output logic [XW+YW-1:0] p
);
    localparam int PW = XW + YW;

    always_comb begin
        p = PW'(x) * PW'(y);
    end
endmodule

// File: rtl/smc_comb_unequal.sv
module smc_comb_unequal #(
    parameter int SA = 25,
    parameter int SB = 18,
    parameter int AH = 15,
    parameter int BH = 14
) (
    input  logic [SA+SB-1:0]       p_ll,
    input  logic [SA+BH-1:0]       p_lh,
    input  logic [AH+SB-1:0]       p_hl,
    input  logic [AH+BH-1:0]       p_hh,
    output logic [SA+SB+AH+BH-1:0] full
);
    import smc_pkg::*;

    localparam int FW  = SA + SB + AH + BH;
    localparam int X1W = AH + SB + SA + 1;
    localparam int X2W = SA + BH + SB + 1;
    localparam int CW  = smc_max(X1W, X2W);

    logic [CW-1:0] cross_a, cross_b, cross_sum;
    logic [FW-1:0] edge_hi, edge_lo, edge_sum;

    // cross-product adder, one spare bit keeps its carry
    always_comb begin
        cross_a   = CW'(p_hl) << SA;
        cross_b   = CW'(p_lh) << SB;
        cross_sum = cross_a + cross_b;
    end

    // disjoint ranges: this sum never carries
    always_comb begin
        edge_hi  = FW'(p_hh) << (SA + SB);
        edge_lo  = FW'(p_ll);
        edge_sum = edge_hi + edge_lo;
    end

    // final adder, anything above FW bits drops off
    always_comb begin
        full = FW'(cross_sum) + edge_sum;
    end
endmodule

// File: rtl/smc_comb_equal.sv
module smc_comb_equal #(
    parameter int S  = 16,
    parameter int AH = 8,
    parameter int BH = 4
) (
    input  logic [2*S-1:0]        p_ll,
    input  logic [S+BH-1:0]       p_lh,
    input  logic [AH+S-1:0]       p_hl,
    input  logic [AH+BH-1:0]      p_hh,
    output logic [2*S+AH+BH-1:0]  full
);
    import smc_pkg::*;

    localparam int FW = 2*S + AH + BH;
    localparam int UW = FW - S;
    localparam int XW = smc_max(AH + S, S + BH) + 1;

    logic [XW-1:0] cross_sum;
    logic [UW-1:0] upper_cat, upper_sum;

    always_comb begin
        cross_sum = XW'(p_hl) + XW'(p_lh);
        upper_cat = {p_hh, p_ll[2*S-1:S]};
        upper_sum = UW'(cross_sum) + upper_cat;
        full      = {upper_sum, p_ll[S-1:0]};
    end
endmodule

// File: rtl/smc_mult.sv
module smc_mult #(
    parameter int A_W     = 40,
    parameter int B_W     = 32,
    parameter int HARD_A  = 18,
    parameter int HARD_B  = 25,
    parameter int P_W     = A_W + B_W,
    parameter bit REG_OUT = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [A_W-1:0] op_a,
    input  logic [B_W-1:0] op_b,
    output logic [P_W-1:0] prod
);
    import smc_pkg::*;

    localparam int SA = smc_split_a(B_W, HARD_A, HARD_B);
    localparam int SB = smc_split_b(B_W, HARD_A, HARD_B);
    localparam int AH = A_W - SA;
    localparam int BH = B_W - SB;
    localparam int FW = A_W + B_W;

    logic [SA-1:0] a_lo;
    logic [AH-1:0] a_hi;
    logic [SB-1:0] b_lo;
    logic [BH-1:0] b_hi;

    always_comb begin
        a_lo = op_a[SA-1:0];
        a_hi = op_a[A_W-1:SA];
        b_lo = op_b[SB-1:0];
        b_hi = op_b[B_W-1:SB];
    end

    logic [SA+SB-1:0] p_ll;
    logic [SA+BH-1:0] p_lh;
    logic [AH+SB-1:0] p_hl;
    logic [AH+BH-1:0] p_hh;

    smc_part_mul #(.XW(SA), .YW(SB)) u_mul_ll (.x(a_lo), .y(b_lo), .p(p_ll));
    smc_part_mul #(.XW(SA), .YW(BH)) u_mul_lh (.x(a_lo), .y(b_hi), .p(p_lh));
    smc_part_mul #(.XW(AH), .YW(SB)) u_mul_hl (.x(a_hi), .y(b_lo), .p(p_hl));
    smc_part_mul #(.XW(AH), .YW(BH)) u_mul_hh (.x(a_hi), .y(b_hi), .p(p_hh));

    logic [FW-1:0]  full;
    logic [P_W-1:0] prod_c;

    generate
        if (SA == SB) begin : g_equal
            smc_comb_equal #(.S(SA), .AH(AH), .BH(BH)) u_comb (
                .p_ll(p_ll), .p_lh(p_lh), .p_hl(p_hl), .p_hh(p_hh), .full(full)
            );
        end else begin : g_unequal
            smc_comb_unequal #(.SA(SA), .SB(SB), .AH(AH), .BH(BH)) u_comb (
                .p_ll(p_ll), .p_lh(p_lh), .p_hl(p_hl), .p_hh(p_hh), .full(full)
            );
        end
    endgenerate

    always_comb begin
        prod_c = full[P_W-1:0];
    end

    generate
        if (REG_OUT) begin : g_reg
            logic [P_W-1:0] prod_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prod_q <= '0;
                else        prod_q <= prod_c;
            end
            assign prod = prod_q;
        end else begin : g_comb
            assign prod = prod_c;
        end
    endgenerate
endmodule

// File: rtl/smc_mult_chk.sv
module smc_mult_chk #(
    parameter int A_W     = 40,
    parameter int B_W     = 32,
    parameter int HARD_A  = 18,
    parameter int HARD_B  = 25,
    parameter int P_W     = A_W + B_W,
    parameter bit REG_OUT = 1'b1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [A_W-1:0] op_a,
    input logic [B_W-1:0] op_b,
    input logic [P_W-1:0] prod
);
    import smc_pkg::*;

    localparam int FW = A_W + B_W;
    localparam int L  = smc_min(smc_split_a(B_W, HARD_A, HARD_B),
                                smc_split_b(B_W, HARD_A, HARD_B));

    logic [FW-1:0]  ref_full;
    logic [P_W-1:0] ref_p;
    logic [2*L-1:0] lo_full;
    logic [L-1:0]   lo_ref;
    logic           any_zero;

    always_comb begin
        ref_full = FW'(op_a) * FW'(op_b);
        ref_p    = ref_full[P_W-1:0];
        lo_full  = (2*L)'(op_a[L-1:0]) * (2*L)'(op_b[L-1:0]);
        lo_ref   = lo_full[L-1:0];
        any_zero = (op_a == '0) || (op_b == '0);
    end

    generate
        if (REG_OUT) begin : g_reg_chk
            // R1
            prod_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> prod == $past(ref_p));
            // R3
            low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> prod[L-1:0] == $past(lo_ref));
            // R8
            zero_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
                any_zero |=> prod == '0);
            // R7
            always @(negedge clk) begin
                if (!rst_n) begin
                    reset_clear_chk: assert (prod == '0);
                end
            end
        end else begin : g_comb_chk
            always @(negedge clk) begin
                if (rst_n) begin
                    // R1
                    prod_comb_chk: assert (prod == ref_p);
                    // R3
                    low_comb_chk: assert (prod[L-1:0] == lo_ref);
                    // R8
                    if (any_zero) begin
                        zero_comb_chk: assert (prod == '0);
                    end
                end
            end
        end
    endgenerate
endmodule

bind smc_mult smc_mult_chk #(
    .A_W(A_W), .B_W(B_W), .HARD_A(HARD_A), .HARD_B(HARD_B), .P_W(P_W), .REG_OUT(REG_OUT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .prod(prod)
);

// File: tb/smc_mult_tb.sv
module smc_mult_tb;
    // unequal split, registered: A split 25 (after swap), B split 18
    localparam int UA = 40, UB = 32, UP = 72;
    // equal split 16/16, combinational, truncated to 36 bits
    localparam int EA = 24, EB = 20, EP = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [UA-1:0] ua = '0;
    logic [UB-1:0] ub = '0;
    logic [UP-1:0] u_prod;
    logic [EA-1:0] ea = '0;
    logic [EB-1:0] eb = '0;
    logic [EP-1:0] e_prod;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    smc_mult #(.A_W(UA), .B_W(UB), .HARD_A(18), .HARD_B(25), .P_W(UP), .REG_OUT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_a(ua), .op_b(ub), .prod(u_prod)
    );

    smc_mult #(.A_W(EA), .B_W(EB), .HARD_A(16), .HARD_B(16), .P_W(EP), .REG_OUT(1'b0)) u_dut_eq (
        .clk(clk), .rst_n(rst_n), .op_a(ea), .op_b(eb), .prod(e_prod)
    );

    function automatic logic [71:0] ref_u(input logic [UA-1:0] a, input logic [UB-1:0] b);
        return 72'(a) * 72'(b);
    endfunction

    function automatic logic [71:0] ref_e(input logic [EA-1:0] a, input logic [EB-1:0] b);
        logic [43:0] f;
        f = 44'(a) * 44'(b);
        return 72'(f[EP-1:0]);
    endfunction

    task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply_u(input logic [UA-1:0] a, input logic [UB-1:0] b, input string req);
        @(negedge clk);
        ua = a;
        ub = b;
        @(negedge clk);
        chk(req, 72'(u_prod), ref_u(a, b));
    endtask

    task automatic apply_e(input logic [EA-1:0] a, input logic [EB-1:0] b, input string req);
        @(negedge clk);
        ea = a;
        eb = b;
        #1;
        chk(req, 72'(e_prod), ref_e(a, b));
    endtask

    // R7: cleared during reset even with live operands
    task automatic t_reset;
        ua = 40'hAB_CDEF_1234;
        ub = 32'h9876_5432;
        @(negedge clk);
        chk("R7 reset", 72'(u_prod), 72'd0);
        @(negedge clk);
        chk("R7 reset held", 72'(u_prod), 72'd0);
        rst_n = 1'b1;
    endtask

    // R6: one-cycle latency on the registered build, none on the other
    task automatic t_latency;
        logic [71:0] old_v;
        @(negedge clk);
        ua = 40'd1000;
        ub = 32'd3;
        @(negedge clk);
        old_v = 72'(u_prod);
        ua = 40'd7;
        ub = 32'd9;
        #1;
        chk("R6 holds before edge", 72'(u_prod), old_v);
        @(negedge clk);
        chk("R6 after edge", 72'(u_prod), 72'd63);
        apply_e(24'd5, 20'd11, "R6 comb same cycle");
    endtask

    // R8
    task automatic t_zero;
        apply_u('0, 32'hFFFF_FFFF, "R8 zero a");
        apply_u(40'hFF_FFFF_FFFF, '0, "R8 zero b");
        apply_e('0, 20'h12345, "R8 zero a eq");
        apply_e(24'hABCDEF, '0, "R8 zero b eq");
    endtask

    // R9 (and R5 on the truncated build)
    task automatic t_ones;
        apply_u('1, '1, "R9 all ones");
        apply_e('1, '1, "R9 R5 all ones eq");
    endtask

    // R2: maximal cross products to force a carry out of the cross sum
    task automatic t_carry;
        apply_u({15'h7FFF, 25'h1FF_FFFF}, {14'h3FFF, 18'h3_FFFF}, "R2 full cross");
        apply_u({15'h7FFF, 25'h000_0000}, {14'h0000, 18'h3_FFFF}, "R2 hl only");
        apply_u({15'h0000, 25'h1FF_FFFF}, {14'h3FFF, 18'h0_0000}, "R2 lh only");
        apply_u({15'h7FFF, 25'h1FF_FFFE}, {14'h3FFF, 18'h3_FFFE}, "R2 near max");
    endtask

    // R1 / R4: random operands on the swapped unequal split
    task automatic t_random_u;
        for (int i = 0; i < 40; i++) begin
            logic [63:0] r;
            r = {$urandom(), $urandom()};
            apply_u(r[UA-1:0], $urandom(), "R1 R4 random");
        end
    endtask

    // R3 / R5: equal split, low bits pass through, truncation
    task automatic t_equal;
        for (int i = 0; i < 40; i++) begin
            logic [EA-1:0] a;
            logic [EB-1:0] b;
            logic [31:0]   lo;
            a = EA'($urandom());
            b = EB'($urandom());
            apply_e(a, b, "R5 random eq");
            lo = 32'(a[15:0]) * 32'(b[15:0]);
            chk("R3 low bits", 72'(e_prod[15:0]), 72'(lo[15:0]));
        end
        apply_e(24'hFF_0001, 20'hF_0001, "R3 low carry pattern");
    endtask

    task automatic finish_run;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        t_reset();
        t_latency();
        t_zero();
        t_ones();
        t_carry();
        t_random_u();
        t_equal();
        done = 1'b1;
        finish_run();
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end
endmodule